// File: doc/BRIEF.md
# Fractional-Period Clock Edge Generator

This block produces the fast waveforms that read out an image sensor and time its correlated double sampler: a reset-gate pulse, two horizontal shift clocks with their complements, and two sample strobes. Every pixel period is cut into 48 equal phase steps. The block runs on a phase clock 48 times faster than the pixel clock. Each waveform is high over a programmable window of steps inside the period.

Each waveform has a rising-step code and a falling-step code. Each code is 6 bits wide and is quadrant-encoded. The reset gate and the two horizontal clocks also have their own polarity invert. A single-cycle alignment input restarts the phase count whenever a pixel-clock rising edge is seen, which keeps the step grid locked to the pixel clock. New settings are taken into use only at a period boundary, so a period never mixes old and new settings.

Top module: `phase_edge_gen`

## Requirements
- R1: An internal phase step counts 0,1,…,47 and then returns to 0. A clock edge at which `pix_align` is high forces the step to 0 on the next cycle, whatever the count was.
- R2: An edge code c decodes to step c[5:4]×12 + c[3:0]. For example, code 0x25 decodes to step 29.
- R3: A code whose low nibble c[3:0] is 12 to 15 is invalid. At a period boundary an invalid code leaves the step held for that field unchanged, and each field is judged on its own.
- R4: When the rising step R is smaller than the falling step F, the active level is high for steps R ≤ s < F and low for all other steps.
- R5: When R is larger than F, the window wraps across the period boundary: the active level is high for s ≥ R or s < F.
- R6: When R equals F, the output sits at its inactive level for the whole period.
- R7: `rgate_inv`, `hca_inv` and `hcb_inv` each invert only their own output (`rgate_o`, `hca_o`, `hcb_o`). The inversion is applied after the window, so with R = F and invert set, the output is constantly high.
- R8: `hca_n_o` is always the complement of `hca_o`, and `hcb_n_o` is always the complement of `hcb_o`.
- R9: `sref_o` and `sdat_o` follow the same windowing on the same step grid and are never inverted.
- R10: Codes and invert inputs are sampled only at the clock edge that starts a new period, when the step wraps from 47 or is aligned. Changes at any other time do not affect the current period.
- R11: During and after a synchronous reset, all held steps and inverts are 0. `rgate_o`, `hca_o`, `hcb_o`, `sref_o` and `sdat_o` are low, and `hca_n_o` and `hcb_n_o` are high.
- R12: An output shows the level for step s one phase-clock cycle after the counter holds s. After an alignment edge E, the level for step k is visible after edge E+1+k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, 48 cycles per pixel period |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_align | input | 1 | One-cycle mark of a pixel-clock rising edge; restarts the step count |
| rgate_rise | input | 6 | Reset-gate rising-step code |
| rgate_fall | input | 6 | Reset-gate falling-step code |
| rgate_inv | input | 1 | Reset-gate polarity invert |
| hca_rise | input | 6 | Horizontal clock A rising-step code |
| hca_fall | input | 6 | Horizontal clock A falling-step code |
| hca_inv | input | 1 | Horizontal clock A polarity invert |
| hcb_rise | input | 6 | Horizontal clock B rising-step code |
| hcb_fall | input | 6 | Horizontal clock B falling-step code |
| hcb_inv | input | 1 | Horizontal clock B polarity invert |
| sref_rise | input | 6 | Reference-sample strobe rising-step code |
| sref_fall | input | 6 | Reference-sample strobe falling-step code |
| sdat_rise | input | 6 | Data-sample strobe rising-step code |
| sdat_fall | input | 6 | Data-sample strobe falling-step code |
| rgate_o | output | 1 | Reset-gate waveform |
| hca_o | output | 1 | Horizontal clock A |
| hca_n_o | output | 1 | Complement of horizontal clock A |
| hcb_o | output | 1 | Horizontal clock B |
| hcb_n_o | output | 1 | Complement of horizontal clock B |
| sref_o | output | 1 | Reference-sample strobe |
| sdat_o | output | 1 | Data-sample strobe |

## Verification
The assertions assume that `pix_align` is a clean synchronous pulse and that every held step is below 48. The second assumption can only fail if an invalid code slipped past the decoder.

The stimulus changes codes, inverts and the alignment pulse only at falling phase-clock edges, so every boundary sample sees settled values. It sweeps all 64 rising codes, invalid ones included, against a spread of falling codes. It also toggles the inverts and places alignment pulses at phases other than 47. Every cycle is compared against an arithmetic model of the step count and the window.

// File: rtl/phase_edge_pkg.sv
// Package: shared geometry of the step grid and code helpers.
// Assumes quadrant count is a power of two so the quadrant field is exact.
package phase_edge_pkg;

    parameter int QUADS      = 4;
    parameter int QUAD_STEPS = 12;
    parameter int NCH        = 5;

    localparam int PERIOD_STEPS = QUADS * QUAD_STEPS;
    localparam int STEP_W       = $clog2(PERIOD_STEPS);
    localparam int QSEL_W       = $clog2(QUADS);
    localparam int POS_W        = 4;
    localparam int CODE_W       = QSEL_W + POS_W;

    // Channel order inside packed vectors
    typedef enum int {
        CH_RGATE = 0,
        CH_HCA   = 1,
        CH_HCB   = 2,
        CH_SREF  = 3,
        CH_SDAT  = 4
    } chan_e;

    // Channels that carry a polarity invert
    localparam logic [NCH-1:0] INV_MASK = 5'b00111;

    // True when the in-quadrant position names a real step
    function automatic logic code_valid(input logic [CODE_W-1:0] code);
        return int'(code[POS_W-1:0]) < QUAD_STEPS;
    endfunction

    // Absolute step from quadrant and in-quadrant position
    function automatic logic [STEP_W-1:0] code_step(input logic [CODE_W-1:0] code);
        return STEP_W'(int'(code[CODE_W-1:POS_W]) * QUAD_STEPS + int'(code[POS_W-1:0]));
    endfunction

endpackage

// File: rtl/phase_step_counter.sv
// Phase step counter: counts phase-clock cycles within a pixel period.
// Assumes pix_align is a synchronous single-cycle pulse; it forces step 0.
// Flags the edge that starts a new period so settings can be loaded there.
module phase_step_counter
    import phase_edge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_align,
    output logic [STEP_W-1:0] step,
    output logic              period_load
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PERIOD_STEPS - 1);

    // Boundary: either the grid wraps or the pixel clock realigns it
    always_comb begin
        period_load = pix_align || (step == LAST_STEP);
    end

    // Advance the step, restarting at each boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= '0;
        end else if (period_load) begin
            step <= '0;
        end else begin
            step <= step + STEP_W'(1);
        end
    end

endmodule

// File: rtl/edge_setting_hold.sv
// Setting hold for one waveform: keeps the decoded rising/falling steps
// and the invert bit used during the current period.
// Assumes load pulses only at a period boundary. Invalid codes keep the old step.
module edge_setting_hold
    import phase_edge_pkg::*;
#(
    parameter bit HAS_INV = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] rise_code,
    input  logic [CODE_W-1:0] fall_code,
    input  logic              inv_in,
    output logic [STEP_W-1:0] rise_step,
    output logic [STEP_W-1:0] fall_step,
    output logic              inv_q
);

    // Rising step: replaced only by a valid code at a boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_step <= '0;
        end else if (load && code_valid(rise_code)) begin
            rise_step <= code_step(rise_code);
        end
    end

    // Falling step: judged independently of the rising code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fall_step <= '0;
        end else if (load && code_valid(fall_code)) begin
            fall_step <= code_step(fall_code);
        end
    end

    generate
        if (HAS_INV) begin : g_inv
            // Invert bit captured at the boundary with the steps
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    inv_q <= 1'b0;
                end else if (load) begin
                    inv_q <= inv_in;
                end
            end
        end else begin : g_no_inv
            // Channel has no invert control
            always_comb begin
                inv_q = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/edge_window_out.sv
// Window shaper for one waveform: compares the current step against the
// held rising/falling steps and registers the level, after polarity.
// Assumes steps are below the period length; equal steps mean inactive.
module edge_window_out
    import phase_edge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STEP_W-1:0] step,
    input  logic [STEP_W-1:0] rise_step,
    input  logic [STEP_W-1:0] fall_step,
    input  logic              inv,
    output logic              wave
);

    logic after_rise;
    logic before_fall;
    logic active;

    // Window membership, wrapping when falling precedes rising
    always_comb begin
        after_rise  = (step >= rise_step);
        before_fall = (step < fall_step);
        if (rise_step == fall_step) begin
            active = 1'b0;
        end else if (rise_step < fall_step) begin
            active = after_rise && before_fall;
        end else begin
            active = after_rise || before_fall;
        end
    end

    // Register the polarity-adjusted level for a glitch-free output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave <= 1'b0;
        end else begin
            wave <= active ^ inv;
        end
    end

endmodule

// File: rtl/phase_edge_gen.sv
// Top: five windowed waveforms on a 48-step grid plus two complements.
// Assumes clk is the 48x phase clock and pix_align marks pixel-clock rises.
module phase_edge_gen
    import phase_edge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_align,
    input  logic [CODE_W-1:0] rgate_rise,
    input  logic [CODE_W-1:0] rgate_fall,
    input  logic              rgate_inv,
    input  logic [CODE_W-1:0] hca_rise,
    input  logic [CODE_W-1:0] hca_fall,
    input  logic              hca_inv,
    input  logic [CODE_W-1:0] hcb_rise,
    input  logic [CODE_W-1:0] hcb_fall,
    input  logic              hcb_inv,
    input  logic [CODE_W-1:0] sref_rise,
    input  logic [CODE_W-1:0] sref_fall,
    input  logic [CODE_W-1:0] sdat_rise,
    input  logic [CODE_W-1:0] sdat_fall,
    output logic              rgate_o,
    output logic              hca_o,
    output logic              hca_n_o,
    output logic              hcb_o,
    output logic              hcb_n_o,
    output logic              sref_o,
    output logic              sdat_o
);

    logic [STEP_W-1:0]            step;
    logic                         period_load;
    logic [NCH-1:0][CODE_W-1:0]   rise_code;
    logic [NCH-1:0][CODE_W-1:0]   fall_code;
    logic [NCH-1:0]               inv_in;
    logic [NCH-1:0][STEP_W-1:0]   rise_step;
    logic [NCH-1:0][STEP_W-1:0]   fall_step;
    logic [NCH-1:0]               inv_q;
    logic [NCH-1:0]               wave;

    // Gather per-channel inputs into indexed vectors
    always_comb begin
        rise_code[CH_RGATE] = rgate_rise;
        rise_code[CH_HCA]   = hca_rise;
        rise_code[CH_HCB]   = hcb_rise;
        rise_code[CH_SREF]  = sref_rise;
        rise_code[CH_SDAT]  = sdat_rise;
        fall_code[CH_RGATE] = rgate_fall;
        fall_code[CH_HCA]   = hca_fall;
        fall_code[CH_HCB]   = hcb_fall;
        fall_code[CH_SREF]  = sref_fall;
        fall_code[CH_SDAT]  = sdat_fall;
        inv_in              = '0;
        inv_in[CH_RGATE]    = rgate_inv;
        inv_in[CH_HCA]      = hca_inv;
        inv_in[CH_HCB]      = hcb_inv;
    end

    phase_step_counter u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_align   (pix_align),
        .step        (step),
        .period_load (period_load)
    );

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
            edge_setting_hold #(
                .HAS_INV (INV_MASK[ch])
            ) u_hold (
                .clk       (clk),
                .rst_n     (rst_n),
                .load      (period_load),
                .rise_code (rise_code[ch]),
                .fall_code (fall_code[ch]),
                .inv_in    (inv_in[ch]),
                .rise_step (rise_step[ch]),
                .fall_step (fall_step[ch]),
                .inv_q     (inv_q[ch])
            );

            edge_window_out u_win (
                .clk       (clk),
                .rst_n     (rst_n),
                .step      (step),
                .rise_step (rise_step[ch]),
                .fall_step (fall_step[ch]),
                .inv       (inv_q[ch]),
                .wave      (wave[ch])
            );
        end
    endgenerate

    // Drive outputs; the complement pairs share one register each
    always_comb begin
        rgate_o = wave[CH_RGATE];
        hca_o   = wave[CH_HCA];
        hca_n_o = ~wave[CH_HCA];
        hcb_o   = wave[CH_HCB];
        hcb_n_o = ~wave[CH_HCB];
        sref_o  = wave[CH_SREF];
        sdat_o  = wave[CH_SDAT];
    end

endmodule

// File: rtl/phase_edge_gen_chk.sv
// Checker for phase_edge_gen: step sequencing, boundary-only loading and
// window levels per channel. Attached to the top through bind below.
module phase_edge_gen_chk
    import phase_edge_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic                       pix_align,
    input logic [STEP_W-1:0]          step,
    input logic                       period_load,
    input logic [NCH-1:0][STEP_W-1:0] rise_step,
    input logic [NCH-1:0][STEP_W-1:0] fall_step,
    input logic [NCH-1:0]             inv_q,
    input logic [NCH-1:0]             wave
);

    localparam logic [STEP_W-1:0] LAST = STEP_W'(PERIOD_STEPS - 1);

    a_r1_align_zero: assert property (@(posedge clk) disable iff (!rst_n)
        pix_align |=> (step == '0));

    a_r1_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (step == LAST) |=> (step == '0));

    a_r1_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_align && step != LAST) |=> (step == $past(step) + STEP_W'(1)));

    a_r1_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(step) < PERIOD_STEPS);

    a_r10_load_starts_period: assert property (@(posedge clk) disable iff (!rst_n)
        period_load |=> (step == '0));

    a_r10_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
        !period_load |=> ($stable(rise_step) && $stable(fall_step) && $stable(inv_q)));

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
            a_r3_steps_valid: assert property (@(posedge clk) disable iff (!rst_n)
                (int'(rise_step[ch]) < PERIOD_STEPS) && (int'(fall_step[ch]) < PERIOD_STEPS));

            a_r6_equal_inactive: assert property (@(posedge clk) disable iff (!rst_n)
                (rise_step[ch] == fall_step[ch]) |=> (wave[ch] == $past(inv_q[ch])));

            a_r4_inside_window: assert property (@(posedge clk) disable iff (!rst_n)
                (rise_step[ch] < fall_step[ch] && step >= rise_step[ch] && step < fall_step[ch])
                |=> (wave[ch] != $past(inv_q[ch])));

            a_r5_wrapped_window: assert property (@(posedge clk) disable iff (!rst_n)
                (rise_step[ch] > fall_step[ch] && (step >= rise_step[ch] || step < fall_step[ch]))
                |=> (wave[ch] != $past(inv_q[ch])));
        end
        for (genvar ch = 0; ch < NCH; ch++) begin : g_noinv
            if (!INV_MASK[ch]) begin : g_r9
                a_r9_never_inverted: assert property (@(posedge clk) disable iff (!rst_n)
                    inv_q[ch] == 1'b0);
            end
        end
    endgenerate

endmodule

bind phase_edge_gen phase_edge_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_align   (pix_align),
    .step        (step),
    .period_load (period_load),
    .rise_step   (rise_step),
    .fall_step   (fall_step),
    .inv_q       (inv_q),
    .wave        (wave)
);

// File: tb/sim_phase_edge_gen.sv
// Bench: arithmetic model of step count, held settings and windows,
// compared against every output at each falling clock edge.
module sim_phase_edge_gen;
    import phase_edge_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    logic pix_align = 1'b0;
    logic [5:0] rgate_rise = '0, rgate_fall = '0, hca_rise = '0, hca_fall = '0;
    logic [5:0] hcb_rise = '0, hcb_fall = '0, sref_rise = '0, sref_fall = '0;
    logic [5:0] sdat_rise = '0, sdat_fall = '0;
    logic rgate_inv = 1'b0, hca_inv = 1'b0, hcb_inv = 1'b0;
    logic rgate_o, hca_o, hca_n_o, hcb_o, hcb_n_o, sref_o, sdat_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int m_ph;
    int m_r [5];
    int m_f [5];
    bit m_inv [5];
    bit m_out [5];

    phase_edge_gen u0 (
        .clk(clk), .rst_n(rst_n), .pix_align(pix_align),
        .rgate_rise(rgate_rise), .rgate_fall(rgate_fall), .rgate_inv(rgate_inv),
        .hca_rise(hca_rise), .hca_fall(hca_fall), .hca_inv(hca_inv),
        .hcb_rise(hcb_rise), .hcb_fall(hcb_fall), .hcb_inv(hcb_inv),
        .sref_rise(sref_rise), .sref_fall(sref_fall),
        .sdat_rise(sdat_rise), .sdat_fall(sdat_fall),
        .rgate_o(rgate_o), .hca_o(hca_o), .hca_n_o(hca_n_o),
        .hcb_o(hcb_o), .hcb_n_o(hcb_n_o), .sref_o(sref_o), .sdat_o(sdat_o)
    );

    function automatic bit ok_code(input logic [5:0] c);
        return c[3:0] < 4'd12;
    endfunction

    function automatic int step_of(input logic [5:0] c);
        return int'(c[5:4]) * 12 + int'(c[3:0]);
    endfunction

    function automatic bit level(input int p, input int r, input int f);
        if (r == f) return 1'b0;
        if (r < f) return (p >= r) && (p < f);
        return (p >= r) || (p < f);
    endfunction

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One phase-clock cycle: update model at the rising edge, compare at the falling edge
    task automatic tick(input string tag);
        logic [5:0] rc [5];
        logic [5:0] fc [5];
        bit iv [5];
        bit load;
        @(posedge clk);
        rc = '{rgate_rise, hca_rise, hcb_rise, sref_rise, sdat_rise};
        fc = '{rgate_fall, hca_fall, hcb_fall, sref_fall, sdat_fall};
        iv = '{rgate_inv, hca_inv, hcb_inv, 1'b0, 1'b0};
        if (!rst_n) begin
            m_ph = 0;
            for (int i = 0; i < 5; i++) begin
                m_r[i] = 0; m_f[i] = 0; m_inv[i] = 0; m_out[i] = 0;
            end
        end else begin
            for (int i = 0; i < 5; i++) m_out[i] = m_inv[i] ^ level(m_ph, m_r[i], m_f[i]);
            load = pix_align || (m_ph == 47);
            m_ph = load ? 0 : m_ph + 1;
            if (load) begin
                for (int i = 0; i < 5; i++) begin
                    if (ok_code(rc[i])) m_r[i] = step_of(rc[i]);
                    if (ok_code(fc[i])) m_f[i] = step_of(fc[i]);
                    m_inv[i] = iv[i];
                end
            end
        end
        @(negedge clk);
        check(tag, "rgate_o", rgate_o, m_out[0]);
        check(tag, "hca_o", hca_o, m_out[1]);
        check(tag, "hcb_o", hcb_o, m_out[2]);
        check("R8", "hca_n_o", hca_n_o, ~m_out[1]);
        check("R8", "hcb_n_o", hcb_n_o, ~m_out[2]);
        check("R9", "sref_o", sref_o, m_out[3]);
        check("R9", "sdat_o", sdat_o, m_out[4]);
    endtask

    task automatic run(input string tag, input int n);
        for (int k = 0; k < n; k++) tick(tag);
    endtask

    initial begin
        // R11: reset state
        run("R11", 3);
        check("R11", "hca_n_o reset", hca_n_o, 1'b1);
        check("R11", "rgate_o reset", rgate_o, 1'b0);
        rst_n = 1'b1;
        run("R11", 50);

        // R2: code 0x25 -> step 29, code 0x26 -> step 30: one-step pulse
        rgate_rise = 6'h25; rgate_fall = 6'h26;
        sref_rise = 6'h25; sref_fall = 6'h26;
        run("R2", 96);

        // R12: align, then window step 0..1 shows right after edge E+1
        rgate_rise = 6'h00; rgate_fall = 6'h01;
        @(negedge clk);
        pix_align = 1'b1;
        tick("R1");
        pix_align = 1'b0;
        tick("R12");
        check("R12", "rgate_o step0", rgate_o, 1'b1);
        tick("R12");
        check("R12", "rgate_o step1", rgate_o, 1'b0);
        run("R12", 60);

        // R1: alignment pulses at arbitrary phases
        for (int a = 0; a < 6; a++) begin
            run("R1", 7 + a * 5);
            pix_align = 1'b1;
            tick("R1");
            pix_align = 1'b0;
        end
        run("R1", 50);

        // R10: change settings mid-period; current period keeps old values
        rgate_rise = 6'h03; rgate_fall = 6'h30;
        run("R10", 60);
        run("R10", 20);
        rgate_rise = 6'h14; rgate_fall = 6'h02; hca_rise = 6'h11; hca_fall = 6'h22;
        run("R10", 96);

        // R7: equal steps with invert set give a constant high on that channel only
        rgate_rise = 6'h05; rgate_fall = 6'h05; rgate_inv = 1'b1;
        hca_rise = 6'h05; hca_fall = 6'h05; hca_inv = 1'b0;
        run("R7", 96);
        check("R7", "rgate_o inverted idle", rgate_o, 1'b1);
        check("R7", "hca_o not inverted", hca_o, 1'b0);

        // R3/R4/R5/R6: sweep every rising code against a spread of falling codes
        for (int ri = 0; ri < 64; ri++) begin
            for (int fi = 0; fi < 64; fi += 5) begin
                logic [5:0] r6, f6;
                string tg;
                r6 = 6'(ri); f6 = 6'(fi);
                if (!ok_code(r6) || !ok_code(f6)) tg = "R3";
                else if (step_of(r6) == step_of(f6)) tg = "R6";
                else if (step_of(r6) < step_of(f6)) tg = "R4";
                else tg = "R5";
                rgate_rise = r6; rgate_fall = f6; rgate_inv = r6[0];
                hca_rise = f6;   hca_fall = r6;   hca_inv = f6[0];
                hcb_rise = r6;   hcb_fall = r6;   hcb_inv = r6[1];
                sref_rise = f6;  sref_fall = r6;
                sdat_rise = r6;  sdat_fall = f6;
                run(tg, 96);
            end
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule